// File: doc/BRIEF.md
# Interleaved Cache Block Fill Controller

This block sits on the memory side of a cache and services block fills. A fill request carries a byte address. The controller keeps the block part of that address, sends it to the DRAM banks in a single address cycle, waits for the common access latency, and then returns the block's words on a shared 32-bit data path. It delivers one word per cycle, lowest address first, and marks the final word.

In the default interleaved build, four one-word-wide banks each hold one word position of every block. Word k of a block sits in bank k at a row equal to the block index. A single strobe starts all four reads together, so one latency period covers the whole block. A 4-word fill then occupies 1 + 15 + 4 = 20 cycles.

A build-time option gives a single-bank variant. It reads the words one after another and pays the latency for every word, which takes 1 + 4×15 + 4 = 65 cycles. This variant is useful for comparing the two organisations. The controller handles one fill at a time and ignores requests that arrive while a fill is in progress.

Top module: `ilv_block_fetch`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_last` and every bit of `bank_rd_en` are low.
- R2: A request is taken only at a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle through the cycle that carries the last word, and low in the cycle after it. An interleaved fill therefore keeps `busy` high for exactly 20 cycles.
- R3: In the first cycle after acceptance, and only while busy, the controller strobes the banks. In interleaved mode all `bank_rd_en` bits go high together and `bank_addr` is the block index, byte-address bits [31:4], zero-extended.
- R4: In interleaved mode the first word appears in the 17th cycle after the accepting edge, which is one address cycle plus 15 latency cycles later. The remaining words follow on the next three consecutive cycles.
- R5: Word k of a fill, for k = 0..3, carries the data of bank k at the strobed row, in ascending order. Exactly four words are delivered per fill.
- R6: `out_last` is high only together with `out_valid`, and only on the fourth word.
- R7: Byte-address bits [3:0] of the request have no effect on the strobed address or on the returned data.
- R8: Requests presented while `busy` is high are ignored. The running fill keeps its address and data, and no new fill starts unless `req_valid` is still high once the controller is idle.
- R9: With `INTERLEAVED` = 0 there is one bank. `bank_addr` is the word address, byte bits [31:2], with bits [1:0] equal to the word index. The controller issues one strobe per word. Word k appears 1 + 16·(k+1) cycles after acceptance, for a `busy` length of 65 cycles.
- R10: `out_valid` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fill request |
| req_addr | input | ADDR_W | Byte address of the requested block |
| busy | output | 1 | Fill in progress |
| bank_rd_en | output | NBANK | Read strobe per bank |
| bank_addr | output | ADDR_W-2 | Row (interleaved) or word address (single bank) |
| bank_rdata | input | NBANK*DATA_W | Read data of all banks, bank 0 in the low bits |
| out_valid | output | 1 | Returned word valid |
| out_data | output | DATA_W | Returned word |
| out_last | output | 1 | Final word of the block |

## Verification
The embedded properties check the handshake on every cycle. Acceptance happens only when idle, and `busy` stays high without a gap until the last word and drops right after it. The address cycle lasts exactly one cycle. Strobes occur only inside a fill, the latched block address is held for the whole fill, and `out_valid` and `out_last` never appear outside a fill.

The exact cycle of each word, word order, data content per bank and total fill length in both builds can only be shown by running fills against bank models. The same holds for ignoring the low address bits and ignoring requests raised in the middle of a fill.

// File: rtl/blk_fetch_pkg.sv
package blk_fetch_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_WAIT = 2'd2,
      ST_XFER = 2'd3
   } fetch_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/blk_fetch_seq.sv
module blk_fetch_seq
   import blk_fetch_pkg::*;
#(
   parameter int WORDS       = 4,
   parameter int LAT         = 15,
   parameter bit INTERLEAVED = 1'b1,
   localparam int WSEL_W     = $clog2(WORDS),
   localparam int CNT_W      = $clog2(LAT + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              busy,
   output logic              accept,
   output logic              addr_phase,
   output logic              xfer,
   output logic              last_word,
   output logic [WSEL_W-1:0] widx
);

   fetch_state_e      state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WSEL_W-1:0] widx_q;
   logic              lat_done;

   if (!is_pow2(WORDS) || WORDS < 2) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("LAT must be at least 1");
   end

   assign busy       = (state_q != ST_IDLE);
   assign accept     = (state_q == ST_IDLE) && req_valid;
   assign addr_phase = (state_q == ST_ADDR);
   assign xfer       = (state_q == ST_XFER);
   assign last_word  = xfer && (widx_q == WSEL_W'(WORDS - 1));
   assign lat_done   = (cnt_q == CNT_W'(LAT - 1));
   assign widx       = widx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         widx_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               widx_q <= '0;
               if (req_valid) state_q <= ST_ADDR;
            end
            ST_ADDR: begin
               cnt_q   <= '0;
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (lat_done) state_q <= ST_XFER;
               else          cnt_q   <= cnt_q + 1'b1;
            end
            ST_XFER: begin
               cnt_q <= '0;
               if (last_word) begin
                  widx_q  <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  widx_q  <= widx_q + 1'b1;
                  state_q <= INTERLEAVED ? ST_XFER : ST_WAIT;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   a_r2_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_word) |=> busy);

   a_r6_last_release: assert property (@(posedge clk) disable iff (!rst_n)
      last_word |=> !busy);

   a_r4_addr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      addr_phase |=> (busy && !addr_phase));

endmodule

// File: rtl/blk_fetch_addr.sv
module blk_fetch_addr #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int WORDS       = 4,
   parameter bit INTERLEAVED = 1'b1,
   localparam int WSEL_W     = $clog2(WORDS),
   localparam int BYTE_SH    = $clog2(DATA_W / 8),
   localparam int OFF_W      = WSEL_W + BYTE_SH,
   localparam int ROW_W      = ADDR_W - OFF_W,
   localparam int BADDR_W    = ADDR_W - BYTE_SH,
   localparam int NBANK      = INTERLEAVED ? WORDS : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic               busy,
   input  logic               addr_phase,
   input  logic               xfer,
   input  logic               last_word,
   input  logic [WSEL_W-1:0]  widx,
   input  logic [ROW_W-1:0]   req_row,
   output logic [NBANK-1:0]   bank_rd_en,
   output logic [BADDR_W-1:0] bank_addr
);

   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (accept) row_q <= req_row;
   end

   if (INTERLEAVED) begin : g_par
      logic unused_par;
      assign unused_par = ^{xfer, last_word, widx};
      assign bank_rd_en = {NBANK{addr_phase}};
      assign bank_addr  = {{WSEL_W{1'b0}}, row_q};
   end else begin : g_ser
      logic [WSEL_W-1:0] next_w;
      assign next_w     = addr_phase ? '0 : (widx + 1'b1);
      assign bank_rd_en = addr_phase | (xfer & ~last_word);
      assign bank_addr  = {row_q, next_w};
   end

   a_r8_row_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(row_q)));

   a_r3_strobe_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_rd_en != '0) |-> busy);

endmodule

// File: rtl/blk_fetch_mux.sv
module blk_fetch_mux #(
   parameter int DATA_W      = 32,
   parameter int WORDS       = 4,
   parameter bit INTERLEAVED = 1'b1,
   localparam int WSEL_W     = $clog2(WORDS),
   localparam int NBANK      = INTERLEAVED ? WORDS : 1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    busy,
   input  logic                    xfer,
   input  logic                    last_word,
   input  logic [WSEL_W-1:0]       widx,
   input  logic [NBANK*DATA_W-1:0] bank_rdata,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_data,
   output logic                    out_last
);

   assign out_valid = xfer;
   assign out_last  = last_word;

   if (INTERLEAVED) begin : g_lanes
      logic [DATA_W-1:0] lane [NBANK];
      for (genvar b = 0; b < NBANK; b++) begin : g_lane
         assign lane[b] = bank_rdata[b*DATA_W +: DATA_W];
      end
      assign out_data = lane[widx];
   end else begin : g_single
      logic unused_single;
      assign unused_single = ^widx;
      assign out_data = bank_rdata[DATA_W-1:0];
   end

   a_r10_valid_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);

   a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

endmodule

// File: rtl/ilv_block_fetch.sv
module ilv_block_fetch
   import blk_fetch_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int WORDS       = 4,
   parameter int LAT         = 15,
   parameter bit INTERLEAVED = 1'b1,
   localparam int WSEL_W     = $clog2(WORDS),
   localparam int BYTE_SH    = $clog2(DATA_W / 8),
   localparam int OFF_W      = WSEL_W + BYTE_SH,
   localparam int ROW_W      = ADDR_W - OFF_W,
   localparam int BADDR_W    = ADDR_W - BYTE_SH,
   localparam int NBANK      = INTERLEAVED ? WORDS : 1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    busy,
   output logic [NBANK-1:0]        bank_rd_en,
   output logic [BADDR_W-1:0]      bank_addr,
   input  logic [NBANK*DATA_W-1:0] bank_rdata,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_data,
   output logic                    out_last
);

   if (DATA_W < 8 || !is_pow2(DATA_W / 8) || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W too small for the block offset");
   end

   logic              accept;
   logic              addr_phase;
   logic              xfer;
   logic              last_word;
   logic [WSEL_W-1:0] widx;
   logic              unused_offset;

   assign unused_offset = ^req_addr[OFF_W-1:0];

   blk_fetch_seq #(
      .WORDS       (WORDS),
      .LAT         (LAT),
      .INTERLEAVED (INTERLEAVED)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .busy       (busy),
      .accept     (accept),
      .addr_phase (addr_phase),
      .xfer       (xfer),
      .last_word  (last_word),
      .widx       (widx)
   );

   blk_fetch_addr #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .WORDS       (WORDS),
      .INTERLEAVED (INTERLEAVED)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .busy       (busy),
      .addr_phase (addr_phase),
      .xfer       (xfer),
      .last_word  (last_word),
      .widx       (widx),
      .req_row    (req_addr[ADDR_W-1:OFF_W]),
      .bank_rd_en (bank_rd_en),
      .bank_addr  (bank_addr)
   );

   blk_fetch_mux #(
      .DATA_W      (DATA_W),
      .WORDS       (WORDS),
      .INTERLEAVED (INTERLEAVED)
   ) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .xfer       (xfer),
      .last_word  (last_word),
      .widx       (widx),
      .bank_rdata (bank_rdata),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_last   (out_last)
   );

endmodule

// File: tb/ilv_block_fetch_tb_top.sv
`timescale 1ns/1ps

package fill_tb_pkg;
   function automatic logic [31:0] mem_word(input int bank, input logic [29:0] a);
      return (32'h9E37_79B9 * {2'b00, a}) ^ (32'h0100_0193 * (bank + 1)) ^ 32'h1357_9BDF;
   endfunction
endpackage

module bank_model #(parameter int ID = 0) (
   input  logic        clk,
   input  logic        rd_en,
   input  logic [29:0] addr,
   output logic [31:0] rdata
);
   logic [29:0] a_q = '0;
   always @(posedge clk) if (rd_en) a_q <= addr;
   assign rdata = fill_tb_pkg::mem_word(ID, a_q);
endmodule

module fill_mon #(parameter bit INTERLEAVED = 1'b1, parameter int LAT = 15, parameter int NB = 4) (
   input  logic          clk,
   input  logic          req_valid,
   input  logic [31:0]   req_addr,
   input  logic          busy,
   input  logic [NB-1:0] strobe,
   input  logic [29:0]   baddr,
   input  logic          out_valid,
   input  logic [31:0]   out_data,
   input  logic          out_last,
   output int            checks,
   output int            fails
);
   logic [27:0] blk = '0;
   int n = 0;
   int k = 0;
   int c_cnt = 0;
   int f_cnt = 0;
   assign checks = c_cnt;
   assign fails  = f_cnt;

   function automatic int word_pos(input int idx);
      return INTERLEAVED ? (2 + LAT + idx) : (1 + (idx + 1) * (LAT + 1));
   endfunction

   function automatic logic [31:0] exp_word(input int idx);
      logic [1:0] w;
      w = idx[1:0];
      return INTERLEAVED ? fill_tb_pkg::mem_word(idx, {2'b00, blk})
                         : fill_tb_pkg::mem_word(0, {blk, w});
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      c_cnt++;
      if (!ok) begin
         f_cnt++;
         $display("FAIL %s %s (%s): actual %0h expected %0h",
                  req, what, INTERLEAVED ? "interleaved" : "single", act, exp);
      end
   endtask

   // R7: only bits [31:4] of the accepted address select the block
   always @(posedge clk) if (req_valid && !busy) blk <= req_addr[31:4];

   always @(negedge clk) begin
      if (busy) begin
         n = n + 1;
         if (n == 1) begin
            chk(strobe == {NB{1'b1}}, "R3", "strobe in address cycle", 32'(strobe), 32'({NB{1'b1}}));
            chk(baddr == (INTERLEAVED ? {2'b00, blk} : {blk, 2'b00}), INTERLEAVED ? "R3" : "R9",
                "bank address", {2'b00, baddr}, INTERLEAVED ? {4'h0, blk} : {2'b00, blk, 2'b00});
         end
         if (out_valid) begin
            chk(n == word_pos(k), INTERLEAVED ? "R4" : "R9", "word slot", n, word_pos(k));
            chk(out_data == exp_word(k), "R5", "word data", out_data, exp_word(k));
            chk(out_last == (k == 3), "R6", "last flag", 32'(out_last), 32'(k == 3));
            k = k + 1;
         end
      end else begin
         if (out_valid) chk(1'b0, "R10", "valid while idle", 1, 0);
         if (n != 0) begin
            chk(n == word_pos(3), INTERLEAVED ? "R2" : "R9", "busy length", n, word_pos(3));
            chk(k == 4, "R5", "words per fill", k, 4);
            n = 0;
            k = 0;
         end
      end
   end
endmodule

module ilv_block_fetch_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   always #2 clk = ~clk;

   logic         busy_i, ov_i, ol_i;
   logic [3:0]   en_i;
   logic [29:0]  ba_i;
   logic [127:0] rd_i;
   logic [31:0]  od_i;
   logic         busy_s, ov_s, ol_s;
   logic [0:0]   en_s;
   logic [29:0]  ba_s;
   logic [31:0]  rd_s;
   logic [31:0]  od_s;

   ilv_block_fetch #(.INTERLEAVED(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .busy(busy_i), .bank_rd_en(en_i), .bank_addr(ba_i), .bank_rdata(rd_i),
      .out_valid(ov_i), .out_data(od_i), .out_last(ol_i));

   ilv_block_fetch #(.INTERLEAVED(1'b0)) dut_s (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .busy(busy_s), .bank_rd_en(en_s), .bank_addr(ba_s), .bank_rdata(rd_s),
      .out_valid(ov_s), .out_data(od_s), .out_last(ol_s));

   for (genvar b = 0; b < 4; b++) begin : g_bank
      bank_model #(.ID(b)) u_bank (.clk(clk), .rd_en(en_i[b]), .addr(ba_i), .rdata(rd_i[b*32 +: 32]));
   end
   bank_model #(.ID(0)) u_bank_s (.clk(clk), .rd_en(en_s[0]), .addr(ba_s), .rdata(rd_s));

   int mc_i, mf_i, mc_s, mf_s;
   fill_mon #(.INTERLEAVED(1'b1), .NB(4)) mon_i (
      .clk(clk), .req_valid(req_valid), .req_addr(req_addr), .busy(busy_i), .strobe(en_i),
      .baddr(ba_i), .out_valid(ov_i), .out_data(od_i), .out_last(ol_i), .checks(mc_i), .fails(mf_i));
   fill_mon #(.INTERLEAVED(1'b0), .NB(1)) mon_s (
      .clk(clk), .req_valid(req_valid), .req_addr(req_addr), .busy(busy_s), .strobe(en_s),
      .baddr(ba_s), .out_valid(ov_s), .out_data(od_s), .out_last(ol_s), .checks(mc_s), .fails(mf_s));

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + mc_i + mc_s, n_fail + mf_i + mf_s);
   endtask

   task automatic wait_idle();
      while (busy_i || busy_s) @(negedge clk);
   endtask

   task automatic run_fill(input logic [31:0] addr, input bit noisy, input logic [31:0] other);
      wait_idle();
      req_valid = 1'b1;
      req_addr  = addr;
      @(negedge clk);
      chk(busy_i && busy_s, "R2", "busy after accept", {busy_i, busy_s}, 2'b11);
      if (noisy) begin
         req_addr = other;   // R8: raised mid-fill, must be ignored
         repeat (8) @(negedge clk);
      end
      req_valid = 1'b0;
      req_addr  = $urandom;
      wait_idle();
      @(negedge clk);
      if (noisy) begin
         repeat (3) begin
            chk(!busy_i && !busy_s && !ov_i && !ov_s, "R8", "no fill from ignored request",
                {busy_i, busy_s, ov_i, ov_s}, 4'b0000);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0A17));
      repeat (5) @(negedge clk);
      chk(!busy_i && !ov_i && !ol_i && en_i == '0, "R1", "reset state interleaved",
          {busy_i, ov_i, ol_i, en_i}, 0);
      chk(!busy_s && !ov_s && !ol_s && en_s == '0, "R1", "reset state single",
          {busy_s, ov_s, ol_s, en_s}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_i && !busy_s, "R1", "idle after reset release", {busy_i, busy_s}, 0);
      run_fill(32'h0000_0000, 1'b0, 0);
      run_fill(32'h0000_0030, 1'b0, 0);
      run_fill(32'h0000_003F, 1'b0, 0);   // R7 low bits set
      run_fill(32'hFFFF_FFF0, 1'b0, 0);
      run_fill(32'hFFFF_FFFB, 1'b0, 0);   // R7 low bits set at top block
      run_fill(32'h0000_1230, 1'b1, 32'h0000_4560);
      run_fill(32'hA5A5_5A5C, 1'b1, 32'h1111_1110);
      for (int i = 0; i < 16; i++) begin
         run_fill($urandom, 1'b0, 0);
      end
      finished = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         report();
         $finish;
      end
   end
endmodule